// File: doc/BRIEF.md
# Cascadable Edge-Selectable Event Counter Group

This block holds a small group of down-counting event counters. Each counter counts events from one of two sources. The first source is an edge of its own input pin, taken through a synchroniser and an edge detector. The counted edge can be falling, rising or both. The second source is the underflow of the previous counter in a fixed ring. In the ring, counter 0 follows the last counter. When a counter steps past zero it reloads from its reload register and raises a one-clock interrupt request. Chaining counters in this way builds longer event dividers.

Software sets up each counter through a simple register bus. A combinational read port and a single-cycle write strobe are all it takes. The word address is split into a counter index (upper bits) and a register select (lowest two bits). Select 0 is the 8-bit mode register, select 1 is the reload register and select 2 reads the live count. The index equal to the number of counters, with select 0, is the shared control register. Bit i of the control register starts counter i.

The mode register has the following fields:
- Bits [1:0] give the operation. Only code 01 counts events.
- Bits [3:2] give the pin edge polarity.
- Bit 7 selects the source. 0 takes events from the pin and 1 takes them from the cascade.
- Bit 4 is stored. Software is expected to write it as 0.
- Bit 5 always reads 0.
- Bit 6 is stored and has no effect.

Top module: `evcnt_group`

## Requirements
- R1: After reset, every mode register, reload register, count value and the control register read 0, and every irq output is low.
- R2: Writing the mode register of counter i (address 4*i) stores bits 7, 6, 4 and [3:0]. Bit 5 always reads back 0, so a write of 0xFF reads back as 0xDF.
- R3: A counter counts only while its start bit (bit i of the control register at address 4*NUM_CNT) is 1 and its mode bits [1:0] are 01. Otherwise its count holds its value and its irq stays low.
- R4: With pin source selected, polarity bits [3:2] work as follows: 00 counts falling edges, 01 counts rising edges, 10 counts both edges, and 11 counts nothing. Each counted event lowers the count by exactly one.
- R5: An event that arrives while the count is 0 loads the count from the reload register. The same event drives irq of that counter high for exactly one clock, in the cycle after that clock edge.
- R6: A write to the reload register (address 4*i+1) of a counter that is not counting also loads its count. A write while it is counting changes only the reload value, which is used at the next underflow.
- R7: With mode bit 7 set to 1, counter i counts underflows of counter i-1, and counter 0 counts underflows of the last counter. For i > 0 the step happens on the same clock edge as the upstream reload. Counter 0 steps one clock after the last counter's reload.
- R8: When mode bit 7 is 1, the counter's own pin and its polarity bits have no effect on its count.
- R9: A pin change placed between two clock edges is counted on the third rising clock edge after the change. The count read after the second edge still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data, combinational from bus_addr |
| evt_pin | input | NUM_CNT | External event inputs, one per counter |
| irq | output | NUM_CNT | One-clock underflow interrupt requests |

## Verification
The bench builds the block with its defaults: three counters, 16-bit counts, a 4-bit address and a two-stage synchroniser. Three counters are enough to reach both cascade paths, the combinational chain from counter 0 to counter 1 and the registered wrap from the last counter back to counter 0. The bench uses small reload values so that random pin sequences under every polarity code reach underflow often. Long chains and the top of the 16-bit count range are not reached at this size.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

   typedef enum logic [1:0] {
      POL_FALL = 2'b00,
      POL_RISE = 2'b01,
      POL_BOTH = 2'b10,
      POL_NONE = 2'b11
   } pol_e;

   localparam logic [1:0] OP_EVENT = 2'b01;

   typedef struct packed {
      logic       src_casc;
      logic       spare6;
      logic       rsv5;
      logic       rsv4;
      pol_e       pol;
      logic [1:0] op;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   localparam logic [1:0] SEL_MODE   = 2'd0;
   localparam logic [1:0] SEL_RELOAD = 2'd1;
   localparam logic [1:0] SEL_COUNT  = 2'd2;

   function automatic mode_t mode_clean(input logic [MODE_W-1:0] raw);
      mode_t m;
      m      = mode_t'(raw);
      m.rsv5 = 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge
   import evcnt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  pol_e pol,
   output logic evt
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evcnt_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur  = sync_q[SYNC_STAGES-1];
   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

   always_comb begin
      unique case (pol)
         POL_FALL: evt = fall;
         POL_RISE: evt = rise;
         POL_BOTH: evt = rise | fall;
         POL_NONE: evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/evcnt_core.sv
module evcnt_core
   import evcnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              reld_wr,
   input  logic [CNT_W-1:0]  reld_wdata,
   input  logic              start,
   input  logic              pin_evt,
   input  logic              casc_evt,
   output mode_t             mode_q,
   output logic [CNT_W-1:0]  reld_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              uf_now,
   output logic              irq
);

   logic run;
   logic evt;
   logic at_zero;

   assign run     = start && (mode_q.op == OP_EVENT);
   assign evt     = mode_q.src_casc ? casc_evt : pin_evt;
   assign at_zero = (cnt_q == '0);
   assign uf_now  = run && evt && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         reld_q <= '0;
         cnt_q  <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= uf_now;
         if (mode_wr) begin
            mode_q <= mode_clean(mode_wdata);
         end
         if (reld_wr) begin
            reld_q <= reld_wdata;
         end
         if (run && evt) begin
            cnt_q <= at_zero ? reld_q : cnt_q - CNT_W'(1);
         end else if (reld_wr && !run) begin
            cnt_q <= reld_wdata;
         end
      end
   end

endmodule

// File: rtl/evcnt_group.sv
module evcnt_group
   import evcnt_pkg::*;
#(
   parameter int NUM_CNT     = 3,
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   input  logic [NUM_CNT-1:0] evt_pin,
   output logic [NUM_CNT-1:0] irq
);

   localparam int IDX_W    = ADDR_W - 2;
   localparam int CTRL_IDX = NUM_CNT;

   if (NUM_CNT < 2) begin : g_bad_num
      $error("evcnt_group: NUM_CNT must be at least 2");
   end
   if (CNT_W < MODE_W || CNT_W < NUM_CNT) begin : g_bad_width
      $error("evcnt_group: CNT_W too narrow for mode or control register");
   end
   if (ADDR_W < 3 || (NUM_CNT + 1) > (1 << IDX_W)) begin : g_bad_addr
      $error("evcnt_group: ADDR_W too small for the register map");
   end

   logic [IDX_W-1:0] idx;
   logic [1:0]       sel;

   assign idx = bus_addr[ADDR_W-1:2];
   assign sel = bus_addr[1:0];

   logic [NUM_CNT-1:0]            mode_wr;
   logic [NUM_CNT-1:0]            reld_wr;
   logic                          ctrl_wr;
   logic [NUM_CNT-1:0]            start_q;
   mode_t [NUM_CNT-1:0]           mode_all;
   logic [NUM_CNT-1:0][CNT_W-1:0] reld_all;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

   always_comb begin
      for (int k = 0; k < NUM_CNT; k++) begin
         mode_wr[k] = bus_wr && (idx == IDX_W'(k)) && (sel == SEL_MODE);
         reld_wr[k] = bus_wr && (idx == IDX_W'(k)) && (sel == SEL_RELOAD);
      end
      ctrl_wr = bus_wr && (idx == IDX_W'(CTRL_IDX)) && (sel == SEL_MODE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (ctrl_wr) begin
         start_q <= bus_wdata[NUM_CNT-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic  casc_in;
      logic  uf_loc;
      logic  pin_evt;
      mode_t mode_loc;

      if (i == 0) begin : g_ring
         assign casc_in = irq[NUM_CNT-1];
      end else begin : g_chain
         assign casc_in = g_cnt[i-1].uf_loc;
      end

      evcnt_edge #(
         .SYNC_STAGES(SYNC_STAGES)
      ) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (evt_pin[i]),
         .pol  (mode_loc.pol),
         .evt  (pin_evt)
      );

      evcnt_core #(
         .CNT_W(CNT_W)
      ) u_core (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_wr   (mode_wr[i]),
         .mode_wdata(bus_wdata[MODE_W-1:0]),
         .reld_wr   (reld_wr[i]),
         .reld_wdata(bus_wdata),
         .start     (start_q[i]),
         .pin_evt   (pin_evt),
         .casc_evt  (casc_in),
         .mode_q    (mode_loc),
         .reld_q    (reld_all[i]),
         .cnt_q     (cnt_all[i]),
         .uf_now    (uf_loc),
         .irq       (irq[i])
      );

      assign mode_all[i] = mode_loc;
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (idx == IDX_W'(k)) begin
            unique case (sel)
               SEL_MODE:   bus_rdata = CNT_W'(mode_all[k]);
               SEL_RELOAD: bus_rdata = reld_all[k];
               SEL_COUNT:  bus_rdata = cnt_all[k];
               default:    bus_rdata = '0;
            endcase
         end
      end
      if (idx == IDX_W'(CTRL_IDX) && sel == SEL_MODE) begin
         bus_rdata = CNT_W'(start_q);
      end
   end

endmodule

// File: rtl/evcnt_group_chk.sv
module evcnt_group_chk #(
   parameter int NUM_CNT = 3,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic                          rd_bit5,
   input logic [NUM_CNT-1:0]            irq,
   input logic [NUM_CNT-1:0]            start_q,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
   input logic [NUM_CNT-1:0][CNT_W-1:0] reld_all
);

   // R2: mode readback never shows bit 5
   a_r2_bit5_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_addr[1:0] == 2'd0) && (int'(bus_addr[ADDR_W-1:2]) < NUM_CNT)) |-> !rd_bit5);

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
      localparam logic [ADDR_W-1:0] RA = ADDR_W'(4 * k + 1);

      // R3: stopped counter holds unless a reload write loads it
      a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
         (!start_q[k] && !(bus_wr && bus_addr == RA)) |=> (cnt_all[k] == $past(cnt_all[k])));

      // R3: stopped counter raises no interrupt
      a_r3_no_irq_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
         !start_q[k] |=> !irq[k]);

      // R4: a count change is a single step, a reload or a written load
      a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_all[k] != $past(cnt_all[k])) |->
            ((cnt_all[k] == $past(cnt_all[k]) - CNT_W'(1)) || irq[k] ||
             $past(bus_wr && bus_addr == RA)));

      // R5: interrupt only follows a count of zero
      a_r5_irq_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
         irq[k] |-> ($past(cnt_all[k]) == '0));

      // R5: interrupt comes with the reload value in the count
      a_r5_reload_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
         irq[k] |-> (cnt_all[k] == $past(reld_all[k])));
   end

endmodule

bind evcnt_group evcnt_group_chk #(
   .NUM_CNT(NUM_CNT),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .rd_bit5 (bus_rdata[5]),
   .irq     (irq),
   .start_q (start_q),
   .cnt_all (cnt_all),
   .reld_all(reld_all)
);

// File: tb/evcnt_group_tb_top.sv
`timescale 1ns/1ps
module evcnt_group_tb_top;

   localparam int NC = 3;
   localparam int CW = 16;
   localparam int AW = 4;
   localparam int CTRL_A = 4 * NC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [CW-1:0] bus_wdata = '0;
   logic [CW-1:0] bus_rdata;
   logic [NC-1:0] evt_pin = '0;
   logic [NC-1:0] irq;

   int n_chk = 0;
   int n_fail = 0;
   int irq_seen [NC];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evcnt_group #(.NUM_CNT(NC), .CNT_W(CW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin), .irq(irq)
   );

   initial for (int i = 0; i < NC; i++) irq_seen[i] = 0;

   always @(negedge clk) begin
      for (int i = 0; i < NC; i++) if (irq[i]) irq_seen[i]++;
   end

   function automatic int a_mode(int i);   return 4 * i;     endfunction
   function automatic int a_reld(int i);   return 4 * i + 1; endfunction
   function automatic int a_cnt(int i);    return 4 * i + 2; endfunction

   function automatic bit edge_hit(int pol, bit old_v, bit new_v);
      case (pol)
         0: return old_v && !new_v;
         1: return !old_v && new_v;
         2: return old_v != new_v;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = CW'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(int a, output int d);
      bus_addr = AW'(a);
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic set_pin(int i, bit v);
      @(negedge clk);
      evt_pin[i] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_irq(int i, output bit hit);
      hit = 1'b0;
      for (int t = 0; t < 12 && !hit; t++) begin
         @(negedge clk);
         if (irq[i]) hit = 1'b1;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      int d, d2, base, mcnt, rl, pol, ci, ucnt;
      bit hit, pv, nv;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < NC; i++) begin
         peek(a_mode(i), d); chk("R1 mode", d, 0);
         peek(a_reld(i), d); chk("R1 reload", d, 0);
         peek(a_cnt(i), d);  chk("R1 count", d, 0);
      end
      peek(CTRL_A, d); chk("R1 ctrl", d, 0);
      chk("R1 irq", int'(irq), 0);

      // R2 mode readback, bit 5 forced low
      wr(a_mode(0), 8'hFF); peek(a_mode(0), d); chk("R2 readback", d, 8'hDF);
      wr(a_mode(0), 8'h00);

      // R6 reload write when stopped / running
      wr(a_mode(0), 8'h05);
      wr(a_reld(0), 7); peek(a_cnt(0), d); chk("R6 stopped load", d, 7);
      wr(CTRL_A, 1);
      wr(a_reld(0), 3); peek(a_cnt(0), d); chk("R6 running keeps count", d, 7);
      peek(a_reld(0), d); chk("R6 running reload value", d, 3);

      // R9 pin latency
      @(negedge clk); evt_pin[0] = 1'b1;
      @(negedge clk); @(negedge clk); peek(a_cnt(0), d); chk("R9 after 2nd edge", d, 7);
      @(negedge clk); peek(a_cnt(0), d); chk("R9 after 3rd edge", d, 6);
      repeat (4) @(negedge clk);

      // R3 stopped, then wrong operation code
      wr(CTRL_A, 0);
      set_pin(0, 0); set_pin(0, 1);
      peek(a_cnt(0), d); chk("R3 stopped holds", d, 6);
      wr(a_mode(0), 8'h04); wr(CTRL_A, 1);
      set_pin(0, 0); set_pin(0, 1);
      peek(a_cnt(0), d); chk("R3 op 00 holds", d, 6);

      // R4 reserved polarity counts nothing, falling counts
      wr(a_mode(0), 8'h0D);
      set_pin(0, 0); set_pin(0, 1);
      peek(a_cnt(0), d); chk("R4 polarity 11", d, 6);
      wr(a_mode(0), 8'h01);
      set_pin(0, 0);
      peek(a_cnt(0), d); chk("R4 falling", d, 5);

      // R5 underflow reload and single irq
      wr(a_mode(0), 8'h09);
      base = irq_seen[0];
      for (int t = 0; t < 5; t++) set_pin(0, (t % 2) == 0);
      peek(a_cnt(0), d); chk("R5 reach zero", d, 0);
      chk("R5 no irq before underflow", irq_seen[0] - base, 0);
      set_pin(0, 0);
      peek(a_cnt(0), d); chk("R5 reload", d, 3);
      chk("R5 one irq pulse", irq_seen[0] - base, 1);

      // R7 chain on same edge
      wr(CTRL_A, 0);
      wr(a_mode(0), 8'h05); wr(a_reld(0), 0);
      wr(a_mode(1), 8'h81); wr(a_reld(1), 5);
      wr(CTRL_A, 3);
      @(negedge clk); evt_pin[0] = 1'b1;
      wait_irq(0, hit);
      chk("R7 upstream irq", int'(hit), 1);
      peek(a_cnt(1), d); chk("R7 same edge step", d, 4);
      repeat (3) @(negedge clk);

      // R7 ring wrap to counter 0
      wr(CTRL_A, 0);
      wr(a_mode(2), 8'h05); wr(a_reld(2), 0);
      wr(a_mode(0), 8'h81); wr(a_reld(0), 5);
      wr(CTRL_A, 5);
      @(negedge clk); evt_pin[2] = 1'b1;
      wait_irq(2, hit);
      chk("R7 last irq", int'(hit), 1);
      peek(a_cnt(0), d); chk("R7 ring not yet", d, 5);
      @(negedge clk); peek(a_cnt(0), d); chk("R7 ring one later", d, 4);
      repeat (3) @(negedge clk);

      // R8 cascaded counter ignores pin and polarity
      wr(CTRL_A, 0);
      wr(a_mode(0), 8'h09); wr(a_reld(0), 0);
      wr(a_mode(1), 8'h8D); wr(a_reld(1), 9);
      wr(CTRL_A, 3);
      for (int t = 0; t < 4; t++) set_pin(1, !evt_pin[1]);
      peek(a_cnt(1), d); chk("R8 pin ignored", d, 9);
      set_pin(0, 0); set_pin(0, 1);
      peek(a_cnt(1), d); chk("R8 cascade counts", d, 7);

      // R4 R5 random pin sequences against a model
      for (int it = 0; it < 40; it++) begin
         ci  = int'($urandom % NC);
         pol = int'($urandom % 4);
         rl  = int'($urandom % 4);
         wr(CTRL_A, 0);
         wr(a_mode(ci), (pol << 2) | 1);
         wr(a_reld(ci), rl);
         wr(CTRL_A, 1 << ci);
         mcnt = rl; ucnt = 0;
         base = irq_seen[ci];
         for (int s = 0; s < 10; s++) begin
            pv = evt_pin[ci];
            nv = bit'($urandom % 2);
            set_pin(ci, nv);
            if (edge_hit(pol, pv, nv)) begin
               if (mcnt == 0) begin mcnt = rl; ucnt++; end
               else mcnt--;
            end
         end
         peek(a_cnt(ci), d2);
         chk("R4 random count", d2, mcnt);
         chk("R5 random irq count", irq_seen[ci] - base, ucnt);
      end

      done = 1'b1;
      summary();
   end

endmodule